// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Data Path

This block sits between a peripheral with a 16-bit data path that makes memory requests and a memory port that is 32 bits wide. The peripheral gives a command with a request address, a byte count and a direction. The block combines the request address with a stored base value by bitwise OR. It then moves the data. On a write, the peripheral's bytes arrive as 16-bit beats. They are staged in a 64-byte buffer and leave as bursts of at most 64 bytes. On a read, the block issues one request for the whole transfer. It takes the 32-bit words that come back and hands them to the peripheral as 16-bit beats.

A mode input selects swap mode or pass-through. In swap mode the two bytes of every 16-bit halfword are exchanged in both directions. Bit 0 of the effective address and bit 0 of the count are also cleared. In pass-through mode the data, the address and the count are used exactly as given, and odd counts are allowed. The mode is sampled when a command is accepted.

Every data interface uses valid/ready. A transfer happens on a rising clock edge where both valid and ready are high. A source that raises valid keeps its valid and payload steady until that edge, and a sink may hold ready low for as long as it needs. The block applies this rule to its own outputs, and it keeps no request or data pending across reset.

Top module: `hsw_dma_path`

## Requirements
- R1: The effective address is the command address ORed bit by bit with the base register. It is not their sum. The base register resets to zero.
- R2: With `swap_en` low at command accept, data bytes pass unchanged, and the effective address and count keep their bit 0. An odd count is allowed: the final 16-bit beat then carries a single byte in bits 7:0.
- R3: With `swap_en` high at command accept, bit 0 of the effective address and bit 0 of the count are cleared before the transfer starts.
- R4: Byte order on writes. In every 16-bit beat, bits 7:0 are the lower-addressed byte. In every 32-bit memory beat, byte lane n (bits 8n+7:8n) holds the byte at offset 4×beat+n from the chunk address, and `mw_nbytes` gives how many lanes are valid, starting at lane 0. In swap mode, the two bytes of each incoming halfword are exchanged before they are stored.
- R5: On reads in swap mode, the two bytes of each halfword taken from a returned word are exchanged before they reach `rd_data`. Lanes 1:0 of a word form the first halfword and lanes 3:2 form the second. Each returned word is packed from the effective address upward.
- R6: A write is sent as chunks of at most 64 bytes. Chunk k has address start+64k and length min(64, remaining bytes) on `mw_len`. Each beat carries min(4, bytes left in the chunk) bytes. `mw_last` marks the final beat of each chunk.
- R7: A chunk is sent only after it is fully staged or the count is exhausted. `mw_valid` stays low while beats are being collected, and `wr_ready` stays low while a chunk drains.
- R8: `done` is high for one cycle, the cycle after the final data handshake of a transfer (the last memory write beat, or the last `rd_data` beat), and only while `cmd_ready` is high.
- R9: An effective count of zero, including a count of 1 in swap mode, raises `done` in the cycle after the command is accepted and makes no memory request.
- R10: `base_we` loads `base_wdata` into the base register only while the block is idle (`cmd_ready` high). A strobe while a transfer is in progress has no effect.
- R11: After reset the block is idle. `cmd_ready` is high, and every valid output, `wr_ready`, `md_ready` and `done` are low.
- R12: A read makes one request on `mr_*` that carries the effective address and the whole effective count. It then accepts ceil(count/4) returned words and delivers ceil(count/2) halfword beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_en | input | 1 | 1 = swap mode, 0 = pass-through; sampled at command accept |
| base_we | input | 1 | Base register load strobe (honoured only when idle) |
| base_wdata | input | AW | Value to load into the base register |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command ready; high exactly when idle |
| cmd_write | input | 1 | 1 = write to memory, 0 = read from memory |
| cmd_addr | input | AW | Request address |
| cmd_len | input | LW | Byte count |
| wr_valid | input | 1 | Peripheral write beat valid |
| wr_ready | output | 1 | Peripheral write beat ready |
| wr_data | input | 16 | Peripheral write beat (bits 7:0 = lower byte) |
| rd_valid | output | 1 | Peripheral read beat valid |
| rd_ready | input | 1 | Peripheral read beat ready |
| rd_data | output | 16 | Peripheral read beat (bits 7:0 = lower byte) |
| mw_valid | output | 1 | Memory write beat valid |
| mw_ready | input | 1 | Memory write beat ready |
| mw_addr | output | AW | Start address of the current chunk |
| mw_len | output | CW | Byte length of the current chunk (1..64) |
| mw_data | output | 32 | Packed chunk bytes, lane 0 first |
| mw_nbytes | output | 3 | Valid lanes in this beat (1..4) |
| mw_last | output | 1 | Final beat of the chunk |
| mr_valid | output | 1 | Memory read request valid |
| mr_ready | input | 1 | Memory read request ready |
| mr_addr | output | AW | Read start address |
| mr_len | output | LW | Read byte count |
| md_valid | input | 1 | Returned read word valid |
| md_ready | output | 1 | Returned read word ready |
| md_data | input | 32 | Returned read word, lane 0 = lowest address |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every response has a fixed distance in cycles from the handshake that causes it. `wr_ready` or `mr_valid` rises in the cycle after the command edge. `mw_valid` rises in the cycle after the last staging beat of a chunk. A returned word shows up on `rd_valid` one cycle after its edge. `done` rises one cycle after the final data handshake, and for an empty transfer one cycle after the command edge. The bench drives its inputs on falling edges and samples 1 ns later, so each check reads a value already registered for the next rising edge. It counts handshakes at those points to place each check: `done` is read in the first sample after the final handshake and again one cycle later. It also records how many beats had been staged when each chunk first appeared. Back-pressure on the memory port and on the read port moves those handshakes in time, but the same counting places every check.

// File: rtl/hsw_pkg.sv
`timescale 1ns/1ps
package hsw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_DRAIN,
    ST_RREQ,
    ST_RWAIT,
    ST_ROUT
  } hsw_state_e;

  // Exchange the two bytes of a halfword when swapping is selected.
  function automatic logic [15:0] hw_order(input logic [15:0] h, input logic swp);
    return swp ? {h[7:0], h[15:8]} : h;
  endfunction
endpackage

// File: rtl/hsw_base_unit.sv
`timescale 1ns/1ps
module hsw_base_unit #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic          swap_en,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  output logic [AW-1:0] eff_addr,
  output logic [LW-1:0] eff_len
);
  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                base_q <= '0;
    else if (base_we && idle)  base_q <= base_wdata;
  end

  // Combine by OR; swap mode forces halfword alignment of address and count.
  assign eff_addr = (cmd_addr | base_q) & ~AW'(swap_en);
  assign eff_len  = cmd_len & ~LW'(swap_en);
endmodule

// File: rtl/hsw_stage_buf.sv
`timescale 1ns/1ps
module hsw_stage_buf #(
  parameter int DEPTH = 32,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PW   = IDXW - 1
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [15:0]     wr_half,
  input  logic [PW-1:0]   rd_pair,
  output logic [31:0]     rd_word
);
  logic [15:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_half;
  end

  assign rd_word = {mem[{rd_pair, 1'b1}], mem[{rd_pair, 1'b0}]};
endmodule

// File: rtl/hsw_dma_path.sv
`timescale 1ns/1ps
module hsw_dma_path
  import hsw_pkg::*;
#(
  parameter int AW       = 32,
  parameter int LW       = 16,
  parameter int CHUNK_HW = 32,
  localparam int CHUNK_BYTES = 2 * CHUNK_HW,
  localparam int CW          = $clog2(CHUNK_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swap_en,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [15:0]   wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [15:0]   rd_data,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [CW-1:0] mw_len,
  output logic [31:0]   mw_data,
  output logic [2:0]    mw_nbytes,
  output logic          mw_last,
  output logic          mr_valid,
  input  logic          mr_ready,
  output logic [AW-1:0] mr_addr,
  output logic [LW-1:0] mr_len,
  input  logic          md_valid,
  output logic          md_ready,
  input  logic [31:0]   md_data,
  output logic          done
);
  localparam int IDXW = $clog2(CHUNK_HW);
  localparam int PW   = IDXW - 1;

  hsw_state_e      state;
  logic            swap_q;
  logic [AW-1:0]   cur_addr;
  logic [LW-1:0]   rem;
  logic [CW-1:0]   fill_cnt;
  logic [CW-1:0]   drain_off;
  logic [IDXW-1:0] hw_idx;
  logic [PW-1:0]   drain_pair;
  logic [31:0]     rword;
  logic            rhalf;
  logic            done_q;

  logic [AW-1:0]   eff_addr;
  logic [LW-1:0]   eff_len;
  logic [LW-1:0]   step;
  logic [CW-1:0]   step_c;
  logic [CW-1:0]   left;
  logic            wr_hs;

  hsw_base_unit #(.AW(AW), .LW(LW)) u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle      (state == ST_IDLE),
    .base_we   (base_we),
    .base_wdata(base_wdata),
    .swap_en   (swap_en),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .eff_addr  (eff_addr),
    .eff_len   (eff_len)
  );

  assign wr_hs = wr_valid && (state == ST_FILL);

  hsw_stage_buf #(.DEPTH(CHUNK_HW)) u_buf (
    .clk    (clk),
    .wr_en  (wr_hs),
    .wr_idx (hw_idx),
    .wr_half(hw_order(wr_data, swap_q)),
    .rd_pair(drain_pair),
    .rd_word(mw_data)
  );

  // Bytes carried by the current halfword beat: two, or one at an odd tail.
  assign step   = (rem >= LW'(2)) ? LW'(2) : LW'(1);
  assign step_c = (rem >= LW'(2)) ? CW'(2) : CW'(1);
  assign left   = fill_cnt - drain_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      swap_q     <= 1'b0;
      cur_addr   <= '0;
      rem        <= '0;
      fill_cnt   <= '0;
      drain_off  <= '0;
      hw_idx     <= '0;
      drain_pair <= '0;
      rword      <= '0;
      rhalf      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (cmd_valid) begin
          swap_q     <= swap_en;
          cur_addr   <= eff_addr;
          rem        <= eff_len;
          fill_cnt   <= '0;
          drain_off  <= '0;
          hw_idx     <= '0;
          drain_pair <= '0;
          rhalf      <= 1'b0;
          if (eff_len == '0) done_q <= 1'b1;
          else               state  <= cmd_write ? ST_FILL : ST_RREQ;
        end
        ST_FILL: if (wr_valid) begin
          rem      <= rem - step;
          fill_cnt <= fill_cnt + step_c;
          hw_idx   <= hw_idx + IDXW'(1);
          if ((fill_cnt + step_c == CW'(CHUNK_BYTES)) || (rem == step)) begin
            state      <= ST_DRAIN;
            drain_off  <= '0;
            drain_pair <= '0;
          end
        end
        ST_DRAIN: if (mw_ready) begin
          if (mw_last) begin
            cur_addr <= cur_addr + AW'(fill_cnt);
            fill_cnt <= '0;
            hw_idx   <= '0;
            if (rem == '0) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              state <= ST_FILL;
            end
          end else begin
            drain_pair <= drain_pair + PW'(1);
            drain_off  <= drain_off + CW'(4);
          end
        end
        ST_RREQ: if (mr_ready) state <= ST_RWAIT;
        ST_RWAIT: if (md_valid) begin
          rword <= md_data;
          rhalf <= 1'b0;
          state <= ST_ROUT;
        end
        ST_ROUT: if (rd_ready) begin
          rem <= rem - step;
          if (rem == step) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else if (rhalf) begin
            state <= ST_RWAIT;
          end else begin
            rhalf <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign wr_ready  = (state == ST_FILL);
  assign mw_valid  = (state == ST_DRAIN);
  assign mw_addr   = cur_addr;
  assign mw_len    = fill_cnt;
  assign mw_nbytes = (left >= CW'(4)) ? 3'd4 : left[2:0];
  assign mw_last   = (left <= CW'(4));
  assign mr_valid  = (state == ST_RREQ);
  assign mr_addr   = cur_addr;
  assign mr_len    = rem;
  assign md_ready  = (state == ST_RWAIT);
  assign rd_valid  = (state == ST_ROUT);
  assign rd_data   = hw_order(rhalf ? rword[31:16] : rword[15:0], swap_q);
  assign done      = done_q;
endmodule

// File: rtl/hsw_dma_path_chk.sv
`timescale 1ns/1ps
module hsw_dma_path_chk #(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int CW          = 7,
  parameter int CHUNK_BYTES = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          wr_ready,
  input logic          mw_valid,
  input logic          mw_ready,
  input logic [AW-1:0] mw_addr,
  input logic [CW-1:0] mw_len,
  input logic [31:0]   mw_data,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [15:0]   rd_data,
  input logic          mr_valid,
  input logic          mr_ready,
  input logic [AW-1:0] mr_addr,
  input logic [LW-1:0] mr_len,
  input logic          done
);
  // R7
  fill_drain_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> !wr_ready);

  // R6
  chunk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> (mw_len != '0) && (mw_len <= CW'(CHUNK_BYTES)));

  // R6
  mw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data) && $stable(mw_len));

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R12
  mr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mr_valid && !mr_ready |=> mr_valid && $stable(mr_addr) && $stable(mr_len));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mw_valid && !rd_valid && !mr_valid);
endmodule

bind hsw_dma_path hsw_dma_path_chk #(
  .AW(AW), .LW(LW), .CW(CW), .CHUNK_BYTES(CHUNK_BYTES)
) u_chk (.*);

// File: tb/hsw_dma_path_test.sv
`timescale 1ns/1ps
module hsw_dma_path_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        swap_en = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [15:0] cmd_len = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_data = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [15:0] rd_data;
  logic        mw_valid;
  logic        mw_ready = 1'b0;
  logic [31:0] mw_addr;
  logic [6:0]  mw_len;
  logic [31:0] mw_data;
  logic [2:0]  mw_nbytes;
  logic        mw_last;
  logic        mr_valid;
  logic        mr_ready = 1'b0;
  logic [31:0] mr_addr;
  logic [15:0] mr_len;
  logic        md_valid = 1'b0;
  logic        md_ready;
  logic [31:0] md_data = '0;
  logic        done;

  always #2 clk = ~clk;

  hsw_dma_path uut (.*);

  int checks = 0;
  int errors = 0;
  int sent_cnt = 0;
  logic [31:0] base_model = '0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] sbyte(input int i);
    return 8'(i * 37 + 5);
  endfunction

  function automatic logic [7:0] mb(input logic [31:0] a);
    return 8'(a * 29 + 11);
  endfunction

  task automatic issue(input bit wr, input logic [31:0] a, input int len, input bit swp);
    @(negedge clk);
    swap_en = swp; cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_len = 16'(len);
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic set_base(input logic [31:0] v);
    @(negedge clk); base_we = 1'b1; base_wdata = v;
    @(negedge clk); base_we = 1'b0;
    base_model = v;
  endtask

  task automatic test_reset();
    @(negedge clk); #1;
    chk(cmd_ready == 1'b1, "R11 cmd_ready after reset", cmd_ready, 1);
    chk({mw_valid, mr_valid, rd_valid, wr_ready, md_ready, done} == 6'b0,
        "R11 outputs quiet after reset", {mw_valid, mr_valid, rd_valid, wr_ready, md_ready, done}, 0);
  endtask

  // Write transfer: feeds halfword beats and checks every memory beat (R1-R4, R6-R8).
  task automatic run_write(input logic [31:0] a, input int len, input bit swp, input bit bp,
                           input bit poke, input string tg);
    logic [31:0] ea;
    int el, nbeats;
    int bad_a = 0, bad_l = 0, bad_d = 0, bad_n = 0, bad_stage = 0, bad_done = 0;
    int got = 0;
    ea = a | base_model;
    el = len;
    if (swp) begin ea[0] = 1'b0; el = el & ~1; end
    nbeats = (el + 1) / 2;
    sent_cnt = 0;
    issue(1'b1, a, len, swp);
    if (poke) begin
      base_we = 1'b1; base_wdata = 32'hFFFF_0F0F;
      @(negedge clk);
      base_we = 1'b0;
    end
    fork
      begin
        for (int k = 0; k < nbeats; k++) begin
          wr_valid = 1'b1;
          wr_data = {sbyte(2 * k + 1), sbyte(2 * k)};
          #1;
          while (!wr_ready) begin @(negedge clk); #1; end
          @(negedge clk);
          sent_cnt++;
        end
        wr_valid = 1'b0;
      end
      begin
        int cbase = 0, boff = 0, cyc = 0, clen, nb;
        bit fin = 0;
        while (!fin) begin
          mw_ready = bp ? ((cyc % 3) != 2) : 1'b1;
          cyc++;
          #1;
          if (done) bad_done++;
          if (mw_valid && mw_ready) begin
            clen = (el - cbase > 64) ? 64 : el - cbase;
            if (mw_addr != ea + 32'(cbase)) begin
              bad_a++;
              $display("FAIL R1 %s chunk addr: actual=%0h expected=%0h", tg, mw_addr, ea + 32'(cbase));
            end
            if (int'(mw_len) != clen) bad_l++;
            if (boff == 0 && sent_cnt != (cbase + clen + 1) / 2) bad_stage++;
            nb = (clen - boff >= 4) ? 4 : clen - boff;
            if (int'(mw_nbytes) != nb || mw_last != (boff + 4 >= clen)) bad_n++;
            for (int n = 0; n < nb; n++) begin
              int si = cbase + boff + n;
              if (mw_data[8 * n +: 8] != (swp ? sbyte(si ^ 1) : sbyte(si))) bad_d++;
            end
            got += nb;
            boff += 4;
            if (boff >= clen) begin
              cbase += clen; boff = 0;
              if (cbase >= el) fin = 1;
            end
          end
          @(negedge clk);
        end
        #1;
        chk(done == 1'b1, {"R8 done after last write beat ", tg}, done, 1);
        @(negedge clk); #1;
        chk(done == 1'b0, {"R8 done is one cycle ", tg}, done, 0);
        mw_ready = 1'b0;
      end
    join
    chk(bad_a == 0, {"R1 R3 chunk addresses ", tg}, bad_a, 0);
    chk(bad_l == 0, {"R6 chunk lengths ", tg}, bad_l, 0);
    chk(bad_n == 0, {"R6 beat byte counts and last ", tg}, bad_n, 0);
    chk(bad_d == 0, {swp ? "R4 swapped write bytes " : "R2 pass-through write bytes ", tg}, bad_d, 0);
    chk(bad_stage == 0, {"R7 chunk sent only once staged ", tg}, bad_stage, 0);
    chk(bad_done == 0, {"R8 no early done ", tg}, bad_done, 0);
    chk(got == el, {"R3 total bytes written ", tg}, got, el);
  endtask

  // Read transfer: serves returned words and checks the halfword beats (R1-R3, R5, R8, R12).
  task automatic run_read(input logic [31:0] a, input int len, input bit swp, input bit bp,
                          input string tg);
    logic [31:0] ea;
    int el, nbeats, nw, wait_c = 0;
    int bad_d = 0, words = 0;
    ea = a | base_model;
    el = len;
    if (swp) begin ea[0] = 1'b0; el = el & ~1; end
    nbeats = (el + 1) / 2;
    nw = (el + 3) / 4;
    mr_ready = 1'b1;
    issue(1'b0, a, len, swp);
    #1;
    while (!mr_valid && wait_c < 20) begin @(negedge clk); #1; wait_c++; end
    chk(mr_addr == ea, {"R1 R12 read request addr ", tg}, mr_addr, ea);
    chk(int'(mr_len) == el, {"R12 read request length ", tg}, mr_len, el);
    @(negedge clk);
    mr_ready = 1'b0;
    fork
      begin
        for (int j = 0; j < nw; j++) begin
          md_valid = 1'b1;
          md_data = {mb(ea + 32'(4 * j + 3)), mb(ea + 32'(4 * j + 2)),
                     mb(ea + 32'(4 * j + 1)), mb(ea + 32'(4 * j))};
          #1;
          while (!md_ready) begin @(negedge clk); #1; end
          @(negedge clk);
          words++;
        end
        md_valid = 1'b0;
      end
      begin
        int k = 0, cyc = 0;
        while (k < nbeats) begin
          rd_ready = bp ? ((cyc % 2) == 0) : 1'b1;
          cyc++;
          #1;
          if (rd_valid && rd_ready) begin
            int i0 = 2 * k;
            logic [7:0] e0, e1;
            e0 = swp ? mb(ea + 32'(i0 ^ 1)) : mb(ea + 32'(i0));
            e1 = swp ? mb(ea + 32'((i0 + 1) ^ 1)) : mb(ea + 32'(i0 + 1));
            if (rd_data[7:0] != e0 || (i0 + 1 < el && rd_data[15:8] != e1)) begin
              bad_d++;
              $display("FAIL R5 %s beat %0d: actual=%0h expected=%0h", tg, k, rd_data, {e1, e0});
            end
            k++;
          end
          @(negedge clk);
        end
        rd_ready = 1'b0;
        #1;
        chk(done == 1'b1, {"R8 done after last read beat ", tg}, done, 1);
        @(negedge clk); #1;
        chk(done == 1'b0, {"R8 read done is one cycle ", tg}, done, 0);
      end
    join
    chk(bad_d == 0, {swp ? "R5 swapped read bytes " : "R2 pass-through read bytes ", tg}, bad_d, 0);
    chk(words == nw, {"R12 returned words consumed ", tg}, words, nw);
  endtask

  task automatic run_zero(input bit wr, input logic [31:0] a, input int len, input bit swp,
                          input string tg);
    bit seen = 0;
    mr_ready = 1'b1;
    issue(wr, a, len, swp);
    #1;
    chk(done == 1'b1, {"R9 immediate done ", tg}, done, 1);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); #1;
      if (mw_valid || mr_valid || wr_ready || !cmd_ready) seen = 1;
    end
    chk(!seen, {"R9 no memory access ", tg}, seen, 0);
    mr_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_write(32'h0000_0100, 10, 1'b1, 1'b0, 1'b0, "swap aligned");
    set_base(32'h0000_3000);
    run_write(32'h0000_1005, 13, 1'b1, 1'b0, 1'b0, "swap odd addr and len");
    run_write(32'h0000_0203, 7, 1'b0, 1'b0, 1'b0, "pass-through odd");
    run_write(32'h0000_0040, 150, 1'b1, 1'b1, 1'b0, "swap three chunks with backpressure");
    run_write(32'h0000_0801, 131, 1'b0, 1'b1, 1'b0, "pass-through three chunks");
    run_write(32'h0000_0010, 6, 1'b1, 1'b0, 1'b1, "R10 base strobe while busy");
    run_write(32'h0000_0000, 4, 1'b1, 1'b0, 1'b0, "R10 base kept after busy strobe");
    run_zero(1'b1, 32'h0000_0020, 1, 1'b1, "swap length one");
    run_zero(1'b0, 32'h0000_0020, 0, 1'b0, "read length zero");
    run_read(32'h0000_0011, 14, 1'b1, 1'b1, "swap read");
    run_read(32'h0000_0402, 9, 1'b0, 1'b0, "pass-through odd read");
    set_base(32'h0000_0000);
    run_read(32'h0000_1234, 6, 1'b1, 1'b0, "R1 base cleared");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule